// File: doc/BRIEF.md
# Bank-Distinct Register Allocator

This block hands out physical register indices for the operands of one instruction, at most three per request, and guarantees that no two operands of the same instruction come from the same register bank. The register space is split into equal banks. Every bank keeps its own first-in first-out list of free registers. A register returns to the list of its bank when it is released.

Operands are assigned one per clock. The first operand is looked up starting at bank 0. Each later operand starts at the bank its predecessor used. If that bank is empty, or already holds an operand of this instruction, the search moves on to the next bank, wrapping around. When no bank qualifies, the block waits until a release makes one available. It never falls back to a bank that is already taken. Once the last operand is placed, a one-cycle done pulse presents all indices together, each with its own valid bit.

A fixed reserved mask removes some registers from allocation for good. A release that names a reserved register, or a register that is already free, is dropped.

Top module: `bank_distinct_alloc`

## Requirements
- R1: After reset, req_ready is 1, done is 0 and out_valid is all zero. Each bank's free list holds that bank's non-reserved registers in ascending order, so from reset, single-operand requests return registers 1, 2, 3 and so on up to 15 (default configuration with register 0 reserved).
- R2: The bank of register index i is i / (NUM_REGS/NUM_BANKS). Operand 0 searches from bank 0. Operand k searches from the bank of operand k-1. The winner is the first bank, in increasing order modulo NUM_BANKS, that has a free register and is not yet used by this instruction. The operand receives the oldest entry of that bank's list.
- R3: At every done pulse, the valid operand indices all lie in distinct banks.
- R4: A released register goes to the tail of its own bank's list and is handed out after the registers already waiting in that bank.
- R5: Reserved registers (bit i of RESERVED_MASK set) are never output. A release naming one is ignored.
- R6: A release naming a register that is currently free is ignored and does not create a second copy.
- R7: When no bank qualifies for the current operand, the block stalls: done stays 0 and no same-bank register is given out.
- R8: A release accepted at the same clock edge as a stalled operand is visible to the search at the next edge. That edge places the operand, and if it is the last operand, done rises after that edge.
- R9: A request is taken at a clock edge where req_valid and req_ready are both 1. If there is no stall, done is 1 for exactly one cycle, following the edge req_count edges after the accepting edge. req_ready is 0 from the accepting edge until the done cycle.
- R10: req_count is between 1 and MAX_OPS. Operand k appears on out_idx[k*IDX_W +: IDX_W]. During done, out_valid bits 0 to req_count-1 are 1 and the rest are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Allocation request |
| req_count | input | OPC_W | Number of operands to allocate, 1 to MAX_OPS |
| req_ready | output | 1 | High when a new request can be taken |
| rel_valid | input | 1 | Release strobe |
| rel_idx | input | IDX_W | Register being returned |
| done | output | 1 | One-cycle pulse when all operands are placed |
| out_idx | output | MAX_OPS*IDX_W | Allocated indices, operand k in slice k |
| out_valid | output | MAX_OPS | Per-operand valid, only during done |

## Verification
The assertions assume that every accepted request carries an operand count between 1 and MAX_OPS, and that releases name registers the environment actually holds, apart from the deliberate reserved and duplicate releases. The bench keeps to this. It tracks which registers it owns and returns only those during its sweeps. Before each request, it releases the oldest held registers until its own bank model shows that the request can complete. Only the directed stall cases are built to violate that condition.

// File: rtl/bda_pkg.sv
// Shared types for the bank-distinct allocator.
package bda_pkg;
    // Controller states: waiting for a request, or placing operands.
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_PICK = 1'b1
    } alloc_state_e;
endpackage

// File: rtl/bda_bank_fifo.sv
// Free list for one bank.
// Holds register indices of bank BANK_ID in arrival order. At reset it is
// loaded with the bank's non-reserved registers in ascending order.
// Assumes BANK_SIZE is a power of two, at least 2. Only registers of this
// bank are ever pushed, and never while already present, so it cannot
// overflow.
module bda_bank_fifo #(
    parameter int                 NUM_REGS  = 16,
    parameter int                 BANK_SIZE = 4,
    parameter int                 BANK_ID   = 0,
    parameter int                 IDX_W     = 4,
    parameter logic [NUM_REGS-1:0] RESERVED = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [IDX_W-1:0] push_idx,
    input  logic             pop,
    output logic [IDX_W-1:0] head_idx,
    output logic             nonempty
);
    localparam int PW = $clog2(BANK_SIZE);
    localparam int CW = $clog2(BANK_SIZE + 1);

    // Number of non-reserved registers in this bank.
    function automatic int init_count();
        int n;
        n = 0;
        for (int j = 0; j < BANK_SIZE; j++) begin
            if (!RESERVED[BANK_ID*BANK_SIZE + j]) n++;
        end
        return n;
    endfunction

    // The slot-th non-reserved register of this bank, in ascending order.
    function automatic logic [IDX_W-1:0] init_entry(int slot);
        int n;
        logic [IDX_W-1:0] r;
        n = 0;
        r = '0;
        for (int j = 0; j < BANK_SIZE; j++) begin
            if (!RESERVED[BANK_ID*BANK_SIZE + j]) begin
                if (n == slot) r = IDX_W'(BANK_ID*BANK_SIZE + j);
                n++;
            end
        end
        return r;
    endfunction

    localparam int INIT_CNT = init_count();

    logic [IDX_W-1:0] mem_q [BANK_SIZE];
    logic [PW-1:0]    rd_q;
    logic [PW-1:0]    wr_q;
    logic [CW-1:0]    cnt_q;

    // Storage, pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < BANK_SIZE; s++) mem_q[s] <= init_entry(s);
            rd_q  <= '0;
            wr_q  <= PW'(INIT_CNT % BANK_SIZE);
            cnt_q <= CW'(INIT_CNT);
        end else begin
            if (push) begin
                mem_q[wr_q] <= push_idx;
                wr_q        <= wr_q + 1'b1;
            end
            if (pop) rd_q <= rd_q + 1'b1;
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (!push && pop) cnt_q <= cnt_q - 1'b1;
        end
    end

    // Oldest entry and occupancy flag.
    assign head_idx = mem_q[rd_q];
    assign nonempty = (cnt_q != '0);
endmodule

// File: rtl/bda_bank_pick.sv
// Rotating-priority bank search.
// Finds the first bank, from start_bank upward and wrapping, whose avail bit
// is set. Assumes NUM_BANKS is a power of two, so index addition wraps on
// its own.
module bda_bank_pick #(
    parameter int NUM_BANKS = 4,
    parameter int BW        = 2
) (
    input  logic [BW-1:0]        start_bank,
    input  logic [NUM_BANKS-1:0] avail,
    output logic                 found,
    output logic [BW-1:0]        pick_bank
);
    // Scan from the far end so the nearest candidate is written last.
    always_comb begin
        found     = 1'b0;
        pick_bank = '0;
        for (int k = NUM_BANKS - 1; k >= 0; k--) begin
            if (avail[start_bank + BW'(k)]) begin
                found     = 1'b1;
                pick_bank = start_bank + BW'(k);
            end
        end
    end
endmodule

// File: rtl/bda_free_map.sv
// Free-register map.
// Tracks which registers are currently free, and filters releases so that
// only registers that are allocated and not reserved are returned. Assumes
// an allocated index is always one that is free.
module bda_free_map #(
    parameter int                  NUM_REGS = 16,
    parameter int                  IDX_W    = 4,
    parameter logic [NUM_REGS-1:0] RESERVED = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rel_valid,
    input  logic [IDX_W-1:0] rel_idx,
    input  logic             alloc_valid,
    input  logic [IDX_W-1:0] alloc_idx,
    output logic             rel_accept
);
    logic [NUM_REGS-1:0] free_q;

    // A release counts only for a held, non-reserved register.
    assign rel_accept = rel_valid && !free_q[rel_idx] && !RESERVED[rel_idx];

    // Set on accepted release, clear on allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_q <= ~RESERVED;
        end else begin
            if (rel_accept)  free_q[rel_idx]   <= 1'b1;
            if (alloc_valid) free_q[alloc_idx] <= 1'b0;
        end
    end
endmodule

// File: rtl/bank_distinct_alloc.sv
// Bank-distinct register allocator, top level.
// Accepts a request for 1 to MAX_OPS operands and places one operand per
// cycle. Every operand comes from a different bank. The search for operand k
// starts at the bank of operand k-1 (bank 0 for the first) and moves on to
// the next bank while the candidate bank is empty or already used. The block
// stalls when no bank qualifies. Assumes NUM_REGS and NUM_BANKS are powers
// of two, with MAX_OPS <= NUM_BANKS.
module bank_distinct_alloc #(
    parameter int                  NUM_REGS      = 16,
    parameter int                  NUM_BANKS     = 4,
    parameter int                  MAX_OPS       = 3,
    parameter logic [NUM_REGS-1:0] RESERVED_MASK = 16'h0001,
    localparam int                 IDX_W         = $clog2(NUM_REGS),
    localparam int                 OPC_W         = $clog2(MAX_OPS + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [OPC_W-1:0]         req_count,
    output logic                     req_ready,
    input  logic                     rel_valid,
    input  logic [IDX_W-1:0]         rel_idx,
    output logic                     done,
    output logic [MAX_OPS*IDX_W-1:0] out_idx,
    output logic [MAX_OPS-1:0]       out_valid
);
    import bda_pkg::*;

    localparam int BANK_SIZE = NUM_REGS / NUM_BANKS;
    localparam int LW        = $clog2(BANK_SIZE);
    localparam int BW        = $clog2(NUM_BANKS);
    localparam int OP_W      = (MAX_OPS > 1) ? $clog2(MAX_OPS) : 1;

    alloc_state_e     state_q;
    logic [OPC_W-1:0] cnt_q;
    logic [OPC_W-1:0] op_q;
    logic [NUM_BANKS-1:0] used_q;
    logic [BW-1:0]    prev_bank_q;
    logic [IDX_W-1:0] lane_q [MAX_OPS];
    logic             done_q;

    logic [NUM_BANKS-1:0] nonempty;
    logic [NUM_BANKS-1:0] push_vec;
    logic [NUM_BANKS-1:0] pop_vec;
    logic [IDX_W-1:0]     head [NUM_BANKS];
    logic [BW-1:0]        start_bank;
    logic [BW-1:0]        pick_bank;
    logic                 found;
    logic                 pick_ok;
    logic [IDX_W-1:0]     pick_idx;
    logic                 rel_accept;
    logic [BW-1:0]        rel_bank;

    // Filter releases against the free map.
    bda_free_map #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W),
        .RESERVED (RESERVED_MASK)
    ) u_free (
        .clk         (clk),
        .rst_n       (rst_n),
        .rel_valid   (rel_valid),
        .rel_idx     (rel_idx),
        .alloc_valid (pick_ok),
        .alloc_idx   (pick_idx),
        .rel_accept  (rel_accept)
    );

    // Bank of a returned register: the upper index bits.
    assign rel_bank = rel_idx[IDX_W-1:LW];

    // One free list per bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign push_vec[b] = rel_accept && (rel_bank == BW'(b));
        assign pop_vec[b]  = pick_ok && (pick_bank == BW'(b));

        bda_bank_fifo #(
            .NUM_REGS  (NUM_REGS),
            .BANK_SIZE (BANK_SIZE),
            .BANK_ID   (b),
            .IDX_W     (IDX_W),
            .RESERVED  (RESERVED_MASK)
        ) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (push_vec[b]),
            .push_idx (rel_idx),
            .pop      (pop_vec[b]),
            .head_idx (head[b]),
            .nonempty (nonempty[b])
        );
    end

    // The first operand searches from bank 0, later ones from the previous bank.
    assign start_bank = (op_q == '0) ? '0 : prev_bank_q;

    // Search for a non-empty bank not yet used by this instruction.
    bda_bank_pick #(
        .NUM_BANKS (NUM_BANKS),
        .BW        (BW)
    ) u_pick (
        .start_bank (start_bank),
        .avail      (nonempty & ~used_q),
        .found      (found),
        .pick_bank  (pick_bank)
    );

    assign pick_ok  = (state_q == ST_PICK) && found;
    assign pick_idx = head[pick_bank];

    // Request sequencing: accept, place operands one per cycle, pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            op_q        <= '0;
            used_q      <= '0;
            prev_bank_q <= '0;
            done_q      <= 1'b0;
            for (int k = 0; k < MAX_OPS; k++) lane_q[k] <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        cnt_q   <= req_count;
                        op_q    <= '0;
                        used_q  <= '0;
                        state_q <= ST_PICK;
                    end
                end
                ST_PICK: begin
                    if (found) begin
                        lane_q[op_q[OP_W-1:0]] <= pick_idx;
                        used_q[pick_bank]      <= 1'b1;
                        prev_bank_q            <= pick_bank;
                        op_q                   <= op_q + 1'b1;
                        if (OPC_W'(op_q + 1'b1) == cnt_q) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign done      = done_q;

    // Output lanes and their valid bits.
    for (genvar k = 0; k < MAX_OPS; k++) begin : g_lane
        assign out_idx[k*IDX_W +: IDX_W] = lane_q[k];
        assign out_valid[k]              = done_q && (OPC_W'(k) < cnt_q);
    end
endmodule

// File: rtl/bank_distinct_alloc_chk.sv
// Property checker for bank_distinct_alloc, bound to every instance.
// Assumes requests carry a legal operand count.
module bank_distinct_alloc_chk #(
    parameter int                  NUM_REGS      = 16,
    parameter int                  NUM_BANKS     = 4,
    parameter int                  MAX_OPS       = 3,
    parameter logic [NUM_REGS-1:0] RESERVED_MASK = 16'h0001,
    localparam int                 IDX_W         = $clog2(NUM_REGS),
    localparam int                 OPC_W         = $clog2(MAX_OPS + 1)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic [OPC_W-1:0]         req_count,
    input logic                     req_ready,
    input logic                     done,
    input logic [MAX_OPS*IDX_W-1:0] out_idx,
    input logic [MAX_OPS-1:0]       out_valid
);
    localparam int LW = $clog2(NUM_REGS / NUM_BANKS);
    localparam int BW = $clog2(NUM_BANKS);

    logic             clash;
    logic             rsv_hit;
    logic [OPC_W-1:0] exp_cnt_q;

    // Pairwise bank comparison of valid lanes, and reserved-index detection.
    always_comb begin
        clash   = 1'b0;
        rsv_hit = 1'b0;
        for (int i = 0; i < MAX_OPS; i++) begin
            if (out_valid[i] && RESERVED_MASK[out_idx[i*IDX_W +: IDX_W]]) rsv_hit = 1'b1;
            for (int j = i + 1; j < MAX_OPS; j++) begin
                if (out_valid[i] && out_valid[j] &&
                    out_idx[i*IDX_W+LW +: BW] == out_idx[j*IDX_W+LW +: BW]) clash = 1'b1;
            end
        end
    end

    // Operand count captured when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)                       exp_cnt_q <= '0;
        else if (req_valid && req_ready)  exp_cnt_q <= req_count;
    end

    AST_REQ_COUNT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |-> (req_count != '0) && (req_count <= OPC_W'(MAX_OPS))); // R10
    AST_BANKS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !clash); // R3
    AST_NO_RESERVED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rsv_hit); // R5
    AST_VALID_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> out_valid == '0); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready); // R9
    AST_VALID_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot0({1'b0, out_valid} + 1'b1)); // R10
    AST_VALID_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $countones(out_valid) == int'(exp_cnt_q)); // R10
endmodule

bind bank_distinct_alloc bank_distinct_alloc_chk #(
    .NUM_REGS      (NUM_REGS),
    .NUM_BANKS     (NUM_BANKS),
    .MAX_OPS       (MAX_OPS),
    .RESERVED_MASK (RESERVED_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_count (req_count),
    .req_ready (req_ready),
    .done      (done),
    .out_idx   (out_idx),
    .out_valid (out_valid)
);

// File: tb/bank_distinct_alloc_tb.sv
// Bench for bank_distinct_alloc in its default configuration: 16 registers,
// 4 banks of 4, register 0 reserved, up to 3 operands.
module bank_distinct_alloc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_count = '0;
    logic        req_ready;
    logic        rel_valid = 1'b0;
    logic [3:0]  rel_idx = '0;
    logic        done;
    logic [11:0] out_idx;
    logic [2:0]  out_valid;

    bank_distinct_alloc u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_count (req_count),
        .req_ready (req_ready),
        .rel_valid (rel_valid),
        .rel_idx   (rel_idx),
        .done      (done),
        .out_idx   (out_idx),
        .out_valid (out_valid)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // Bench model of the bank free lists.
    int q [4][4];
    int qh [4];
    int qn [4];
    bit freeb [16];
    int live [16];
    int lh = 0;
    int ln = 0;
    int seed = 32'h1234_5678;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) & 32'h7fff;
    endfunction

    function automatic void model_push(int r);
        int b;
        b = r / 4;
        q[b][(qh[b] + qn[b]) % 4] = r;
        qn[b]++;
    endfunction

    function automatic void model_init();
        for (int b = 0; b < 4; b++) begin
            qh[b] = 0;
            qn[b] = 0;
        end
        for (int r = 0; r < 16; r++) begin
            freeb[r] = (r != 0);
            if (r != 0) model_push(r);
        end
        lh = 0;
        ln = 0;
    endfunction

    function automatic void model_release(int r);
        if (r != 0 && !freeb[r]) begin
            freeb[r] = 1'b1;
            model_push(r);
        end
    endfunction

    // Predicted picks: each operand takes the first usable bank from its start.
    function automatic bit model_plan(int cnt, output int picks [3]);
        bit used [4];
        int prev;
        bit ok;
        ok = 1'b1;
        prev = 0;
        for (int b = 0; b < 4; b++) used[b] = 1'b0;
        for (int k = 0; k < 3; k++) picks[k] = 0;
        for (int k = 0; k < cnt; k++) begin
            int start;
            bit fnd;
            start = (k == 0) ? 0 : prev;
            fnd = 1'b0;
            for (int s = 0; s < 4; s++) begin
                int b;
                b = (start + s) % 4;
                if (!fnd && qn[b] > 0 && !used[b]) begin
                    fnd = 1'b1;
                    used[b] = 1'b1;
                    picks[k] = q[b][qh[b]];
                    prev = b;
                end
            end
            if (!fnd) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic void model_commit(int cnt, int picks [3]);
        for (int k = 0; k < cnt; k++) begin
            int b;
            b = picks[k] / 4;
            qh[b] = (qh[b] + 1) % 4;
            qn[b]--;
            freeb[picks[k]] = 1'b0;
            live[(lh + ln) % 16] = picks[k];
            ln++;
        end
    endfunction

    task automatic do_release(input int r);
        @(negedge clk);
        rel_valid = 1'b1;
        rel_idx   = 4'(r);
        @(negedge clk);
        rel_valid = 1'b0;
        model_release(r);
    endtask

    task automatic release_oldest();
        int r;
        r = live[lh];
        lh = (lh + 1) % 16;
        ln--;
        do_release(r);
    endtask

    // Issue a request the model says can complete, and compare lanes and timing.
    task automatic do_alloc(input int cnt, input string tag);
        int picks [3];
        int edges;
        bit ok;
        ok = model_plan(cnt, picks);
        check(ok, "bench plan", 0, 1);
        @(negedge clk);
        check(req_ready == 1'b1, "R9 ready before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_count = 2'(cnt);
        @(negedge clk);
        req_valid = 1'b0;
        edges = 0;
        while (!done && edges < 40) begin
            @(negedge clk);
            edges++;
        end
        check(edges == cnt, "R9 done latency", edges, cnt);
        check(out_valid == 3'((1 << cnt) - 1), "R10 out_valid", int'(out_valid), (1 << cnt) - 1);
        for (int k = 0; k < cnt; k++) begin
            check(int'(out_idx[k*4 +: 4]) == picks[k], tag, int'(out_idx[k*4 +: 4]), picks[k]);
        end
        model_commit(cnt, picks);
        @(negedge clk);
        check(done == 1'b0, "R9 done one cycle", int'(done), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_init();
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        model_init();
        repeat (3) @(negedge clk);
        // R1: reset state of the outputs.
        check(req_ready == 1'b1, "R1 req_ready at reset", int'(req_ready), 1);
        check(done == 1'b0, "R1 done at reset", int'(done), 0);
        check(out_valid == 3'b000, "R1 out_valid at reset", int'(out_valid), 0);
        rst_n = 1'b1;

        // R1, R2: single-operand requests walk 1..15 in ascending order.
        for (int i = 0; i < 15; i++) do_alloc(1, "R1 R2 initial order");

        // R7: only bank 1 is free, so a two-operand request must stall on operand 1.
        do_release(5);
        @(negedge clk);
        req_valid = 1'b1;
        req_count = 2'd2;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(done == 1'b0, "R7 stall with one bank", int'(done), 0);
        end
        // R8: a release during the stall completes the request one edge later.
        rel_valid = 1'b1;
        rel_idx   = 4'd9;
        @(negedge clk);
        rel_valid = 1'b0;
        check(done == 1'b0, "R8 not yet at release edge", int'(done), 0);
        @(negedge clk);
        check(done == 1'b1, "R8 done after release", int'(done), 1);
        check(int'(out_idx[3:0]) == 5, "R2 R8 lane 0", int'(out_idx[3:0]), 5);
        check(int'(out_idx[7:4]) == 9, "R3 R8 lane 1", int'(out_idx[7:4]), 9);
        begin
            int pk [3];
            model_release(5);
            model_release(9);
            void'(model_plan(2, pk));
            model_commit(2, pk);
        end
        @(negedge clk);

        // R5, R6: reserved and duplicate releases are dropped.
        do_release(0);
        do_release(3);
        do_release(3);
        do_release(2);
        do_alloc(1, "R5 R6 first after filtered releases");
        do_alloc(1, "R4 R6 second after filtered releases");

        // Sweep from a fresh reset: mixed counts and releases.
        do_reset();
        for (int it = 0; it < 400; it++) begin
            int cnt;
            int nrel;
            int pk [3];
            nrel = rnd() % 3;
            for (int j = 0; j < nrel; j++) if (ln > 0) release_oldest();
            cnt = 1 + rnd() % 3;
            while (!model_plan(cnt, pk) && ln > 0) release_oldest();
            do_alloc(cnt, "R2 R3 R4 sweep lane");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule